// File: doc/BRIEF.md
# Codec Port Register and FIFO Hub

This block is the host-facing register and buffering layer of a multimedia codec port. It sits between a simple register bus and a frame engine. The frame engine builds and splits the serial frames that go to an external codec. Two sample channels, audio and telecom, each get their own transmit FIFO and receive FIFO. Either channel can therefore send and receive at the same time. Samples move between the FIFOs and the frame engine through valid/ready handshakes.

A 21-bit command register carries reads and writes for the codec's own control registers. Its written value is offered to the frame engine, and the reply that comes back is stored for the host to read. A status register gathers several conditions: sticky FIFO error flags, level-driven service requests, fill indications and the codec's per-channel enable state. A single interrupt output is the OR of the interrupt-capable status bits, each gated by its mask in the control register. Clearing the port enable empties all four FIFOs and drops the error flags.

Top module: `codec_port_hub`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x0505, `irq` is low, and no transmit sample is offered and no receive sample is accepted.
- R2: The control register holds the port enable in bit 0, the external bit-clock select in bit 1, the audio rate in bits 5:2 and the telecom rate in bits 9:6. It holds the service-request masks in bits 13:10 (audio TX, audio RX, telecom TX, telecom RX) and the error interrupt enable in bit 14. A read returns the stored value, and the `cfg_*` outputs follow it.
- R3: Writing register address 1 pushes bits 15:0 into the audio TX FIFO, and the frame engine receives those samples on the audio TX handshake in write order. Reading address 1 pops the audio RX FIFO and returns its oldest sample in bits 15:0. A read of an empty RX FIFO returns 0.
- R4: Register address 2 does the same with the telecom FIFOs, and traffic on one channel never shows up on the other.
- R5: Each FIFO holds 8 samples. A host write to a full TX FIFO is dropped. A receive FIFO that is full holds its ready low, and a sample offered to it then sets that channel's RX overrun flag (status bit 5 for audio, bit 7 for telecom).
- R6: While the port is enabled, a TX ready from the frame engine that finds the TX FIFO empty sets the channel's TX underrun flag (status bit 4 for audio, bit 6 for telecom). Error flags stay set until a 1 is written to their bit of the status register (address 4).
- R7: The TX service request (status bit 0 for audio, bit 2 for telecom) is high while the TX FIFO holds 4 or fewer samples. The RX service request (bit 1 for audio, bit 3 for telecom) is high while the RX FIFO holds 4 or more samples.
- R8: A write to address 3 stores bits 20:0, raises `cx_req_valid` with that value until `cx_req_ready`, and clears the access-complete flag (status bit 12). A `cx_rsp_valid` pulse stores the reply and sets the flag. A read of address 3 returns the stored reply.
- R9: Status bits 8 to 11 show audio TX not full, audio RX not empty, telecom TX not full and telecom RX not empty. Bits 13 and 14 mirror `aud_codec_on` and `tel_codec_on`. None of these bits affects `irq`.
- R10: `irq` is high when any service request has its mask bit set, or when the error interrupt enable is set and any error flag is set.
- R11: While the port enable is 0, all four FIFOs are held empty, error flags are held clear, no sample is offered or accepted, and an empty-FIFO TX ready sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select: 0 control, 1 audio data, 2 telecom data, 3 codec access, 4 status |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_rd | input | 1 | Register read strobe; pops an RX FIFO on addresses 1 and 2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address and state |
| cfg_enable | output | 1 | Port enable |
| cfg_ext_clk | output | 1 | External bit-clock select |
| cfg_aud_rate | output | 4 | Audio sample-rate code |
| cfg_tel_rate | output | 4 | Telecom sample-rate code |
| aud_tx_valid | output | 1 | Audio TX sample available |
| aud_tx_ready | input | 1 | Frame engine takes an audio TX sample |
| aud_tx_data | output | 16 | Audio TX sample |
| aud_rx_valid | input | 1 | Frame engine offers an audio RX sample |
| aud_rx_ready | output | 1 | Audio RX FIFO can accept |
| aud_rx_data | input | 16 | Audio RX sample |
| tel_tx_valid | output | 1 | Telecom TX sample available |
| tel_tx_ready | input | 1 | Frame engine takes a telecom TX sample |
| tel_tx_data | output | 16 | Telecom TX sample |
| tel_rx_valid | input | 1 | Frame engine offers a telecom RX sample |
| tel_rx_ready | output | 1 | Telecom RX FIFO can accept |
| tel_rx_data | input | 16 | Telecom RX sample |
| cx_req_valid | output | 1 | Codec access command pending |
| cx_req_ready | input | 1 | Frame engine takes the command |
| cx_req_data | output | 21 | Codec access command |
| cx_rsp_valid | input | 1 | Codec access reply strobe |
| cx_rsp_data | input | 21 | Codec access reply |
| aud_codec_on | input | 1 | Codec audio section enabled |
| tel_codec_on | input | 1 | Codec telecom section enabled |
| irq | output | 1 | Interrupt request |

## Verification
A FIFO pointer or count that goes wrong shows up within a single handshake. Samples leave in the wrong order, or valid and ready disagree with the number of samples the host has pushed, and the service-request and not-full bits cross their thresholds at the wrong fill. A wrong error-flag state appears on the next status read and on `irq` one cycle after the triggering handshake. A stale access-complete flag appears on the first status read after a command write or a reply strobe. The directed scenarios fill each FIFO to both thresholds and past full, drain it past empty, toggle the enable with data and errors pending, and walk a codec access through its request and reply.

// File: rtl/cph_pkg.sv
package cph_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_AUD   = 3'd1,
    SEL_TEL   = 3'd2,
    SEL_CODEC = 3'd3,
    SEL_STAT  = 3'd4
  } reg_sel_e;

  // transmit side wants data while it is at most half full
  function automatic logic tx_wants_data(input int fill, input int depth);
    return (2 * fill) <= depth;
  endfunction

  // receive side wants draining once it is at least half full
  function automatic logic rx_wants_drain(input int fill, input int depth);
    return (2 * fill) >= depth;
  endfunction

endpackage

// File: rtl/cph_fifo.sv
module cph_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(wr_ptr)));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/cph_channel.sv
module cph_channel
  import cph_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             host_push,
  input  logic [WIDTH-1:0] host_data,
  input  logic             host_pop,
  output logic [WIDTH-1:0] host_head,
  output logic             eng_tx_valid,
  input  logic             eng_tx_ready,
  output logic [WIDTH-1:0] eng_tx_data,
  input  logic             eng_rx_valid,
  output logic             eng_rx_ready,
  input  logic [WIDTH-1:0] eng_rx_data,
  input  logic             clr_urun,
  input  logic             clr_orun,
  output logic             tx_svc,
  output logic             rx_svc,
  output logic             tx_nf,
  output logic             rx_ne,
  output logic             tx_urun,
  output logic             rx_orun
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] tx_count, rx_count;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             flush;
  // named internal events
  logic             slot_missed, rx_dropped, tx_take, rx_take;

  assign flush        = !enable;
  assign eng_tx_valid = enable && !tx_empty;
  assign eng_rx_ready = enable && !rx_full;
  assign tx_take      = eng_tx_valid && eng_tx_ready;
  assign rx_take      = eng_rx_valid && eng_rx_ready;
  assign slot_missed  = enable && eng_tx_ready && tx_empty;
  assign rx_dropped   = enable && eng_rx_valid && rx_full;

  cph_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(host_push), .din(host_data),
    .pop(tx_take), .dout(eng_tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  cph_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_take), .din(eng_rx_data),
    .pop(host_pop), .dout(host_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  assign tx_svc = tx_wants_data(int'(tx_count), DEPTH);
  assign rx_svc = rx_wants_drain(int'(rx_count), DEPTH);
  assign tx_nf  = !tx_full;
  assign rx_ne  = !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_urun <= 1'b0;
      rx_orun <= 1'b0;
    end else if (!enable) begin
      tx_urun <= 1'b0;
      rx_orun <= 1'b0;
    end else begin
      if (slot_missed)   tx_urun <= 1'b1;
      else if (clr_urun) tx_urun <= 1'b0;
      if (rx_dropped)    rx_orun <= 1'b1;
      else if (clr_orun) rx_orun <= 1'b0;
    end
  end

  // R6
  urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_missed |=> tx_urun);

  // R5
  orun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dropped |=> rx_orun);

  // R6
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_urun && enable && !clr_urun) |=> tx_urun);

  // R11
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tx_urun && !rx_orun));

endmodule

// File: rtl/cph_codec_acc.sv
module cph_codec_acc #(
  parameter int CMD_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [CMD_W-1:0] host_data,
  output logic [CMD_W-1:0] reply,
  output logic             done,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [CMD_W-1:0] req_data,
  input  logic             rsp_valid,
  input  logic [CMD_W-1:0] rsp_data
);
  logic req_taken;
  assign req_taken = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_data  <= '0;
      reply     <= '0;
      done      <= 1'b0;
    end else begin
      if (host_wr) begin
        req_valid <= 1'b1;
        req_data  <= host_data;
      end else if (req_taken) begin
        req_valid <= 1'b0;
      end
      if (rsp_valid) reply <= rsp_data;
      if (host_wr)        done <= 1'b0;
      else if (rsp_valid) done <= 1'b1;
    end
  end

  // R8
  wr_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !done);

  // R8
  rsp_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !host_wr) |=> done);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !host_wr) |=> (req_valid && $stable(req_data)));

endmodule

// File: rtl/codec_port_hub.sv
module codec_port_hub
  import cph_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SAMPLE_W = 16,
  parameter int CMD_W    = 21,
  parameter int RATE_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                cfg_enable,
  output logic                cfg_ext_clk,
  output logic [RATE_W-1:0]   cfg_aud_rate,
  output logic [RATE_W-1:0]   cfg_tel_rate,
  output logic                aud_tx_valid,
  input  logic                aud_tx_ready,
  output logic [SAMPLE_W-1:0] aud_tx_data,
  input  logic                aud_rx_valid,
  output logic                aud_rx_ready,
  input  logic [SAMPLE_W-1:0] aud_rx_data,
  output logic                tel_tx_valid,
  input  logic                tel_tx_ready,
  output logic [SAMPLE_W-1:0] tel_tx_data,
  input  logic                tel_rx_valid,
  output logic                tel_rx_ready,
  input  logic [SAMPLE_W-1:0] tel_rx_data,
  output logic                cx_req_valid,
  input  logic                cx_req_ready,
  output logic [CMD_W-1:0]    cx_req_data,
  input  logic                cx_rsp_valid,
  input  logic [CMD_W-1:0]    cx_rsp_data,
  input  logic                aud_codec_on,
  input  logic                tel_codec_on,
  output logic                irq
);
  localparam int NUM_CH  = 2;
  localparam int EN_B    = 0;
  localparam int EXT_B   = 1;
  localparam int AR_LO   = 2;
  localparam int TR_LO   = AR_LO + RATE_W;
  localparam int MASK_LO = TR_LO + RATE_W;
  localparam int ERR_B   = MASK_LO + 2 * NUM_CH;
  localparam int CTRL_W  = ERR_B + 1;
  localparam int ERR_LO  = 2 * NUM_CH;
  localparam int FLG_LO  = 4 * NUM_CH;
  localparam int DONE_B  = 6 * NUM_CH;
  localparam int STAT_W  = DONE_B + 1 + NUM_CH;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [STAT_W-1:0]   stat;
  logic                enable, ctrl_wr, stat_wr, cx_wr, cx_done;
  logic [CMD_W-1:0]    cx_reply;
  logic                unused_hi;

  logic [NUM_CH-1:0]   ch_push, ch_pop, ch_tx_valid, ch_tx_ready, ch_rx_valid, ch_rx_ready;
  logic [NUM_CH-1:0]   ch_tx_svc, ch_rx_svc, ch_tx_nf, ch_rx_ne, ch_urun, ch_orun;
  logic [NUM_CH-1:0]   ch_clr_urun, ch_clr_orun, ch_on;
  logic [SAMPLE_W-1:0] ch_tx_data [NUM_CH];
  logic [SAMPLE_W-1:0] ch_rx_data [NUM_CH];
  logic [SAMPLE_W-1:0] ch_head    [NUM_CH];
  logic [2*NUM_CH-1:0] svc_vec, err_vec;

  assign unused_hi = ^reg_wdata[31:CMD_W];

  assign enable  = ctrl_q[EN_B];
  assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);
  assign stat_wr = reg_wr && (reg_addr == SEL_STAT);
  assign cx_wr   = reg_wr && (reg_addr == SEL_CODEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  assign cfg_enable   = enable;
  assign cfg_ext_clk  = ctrl_q[EXT_B];
  assign cfg_aud_rate = ctrl_q[AR_LO +: RATE_W];
  assign cfg_tel_rate = ctrl_q[TR_LO +: RATE_W];

  assign ch_tx_ready = {tel_tx_ready, aud_tx_ready};
  assign ch_rx_valid = {tel_rx_valid, aud_rx_valid};
  assign ch_on       = {tel_codec_on, aud_codec_on};
  assign ch_rx_data[0] = aud_rx_data;
  assign ch_rx_data[1] = tel_rx_data;
  assign aud_tx_valid = ch_tx_valid[0];
  assign tel_tx_valid = ch_tx_valid[1];
  assign aud_tx_data  = ch_tx_data[0];
  assign tel_tx_data  = ch_tx_data[1];
  assign aud_rx_ready = ch_rx_ready[0];
  assign tel_rx_ready = ch_rx_ready[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_push[c]     = reg_wr && (reg_addr == 3'(int'(SEL_AUD) + c));
    assign ch_pop[c]      = reg_rd && (reg_addr == 3'(int'(SEL_AUD) + c));
    assign ch_clr_urun[c] = stat_wr && reg_wdata[ERR_LO + 2*c];
    assign ch_clr_orun[c] = stat_wr && reg_wdata[ERR_LO + 2*c + 1];

    cph_channel #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .host_push(ch_push[c]), .host_data(reg_wdata[SAMPLE_W-1:0]),
      .host_pop(ch_pop[c]), .host_head(ch_head[c]),
      .eng_tx_valid(ch_tx_valid[c]), .eng_tx_ready(ch_tx_ready[c]),
      .eng_tx_data(ch_tx_data[c]),
      .eng_rx_valid(ch_rx_valid[c]), .eng_rx_ready(ch_rx_ready[c]),
      .eng_rx_data(ch_rx_data[c]),
      .clr_urun(ch_clr_urun[c]), .clr_orun(ch_clr_orun[c]),
      .tx_svc(ch_tx_svc[c]), .rx_svc(ch_rx_svc[c]),
      .tx_nf(ch_tx_nf[c]), .rx_ne(ch_rx_ne[c]),
      .tx_urun(ch_urun[c]), .rx_orun(ch_orun[c])
    );

    assign svc_vec[2*c]              = ch_tx_svc[c];
    assign svc_vec[2*c+1]            = ch_rx_svc[c];
    assign err_vec[2*c]              = ch_urun[c];
    assign err_vec[2*c+1]            = ch_orun[c];
    assign stat[FLG_LO + 2*c]        = ch_tx_nf[c];
    assign stat[FLG_LO + 2*c + 1]    = ch_rx_ne[c];
    assign stat[DONE_B + 1 + c]      = ch_on[c];
  end

  assign stat[ERR_LO-1:0]      = svc_vec;
  assign stat[FLG_LO-1:ERR_LO] = err_vec;
  assign stat[DONE_B]          = cx_done;

  cph_codec_acc #(.CMD_W(CMD_W)) u_cx (
    .clk(clk), .rst_n(rst_n),
    .host_wr(cx_wr), .host_data(reg_wdata[CMD_W-1:0]),
    .reply(cx_reply), .done(cx_done),
    .req_valid(cx_req_valid), .req_ready(cx_req_ready), .req_data(cx_req_data),
    .rsp_valid(cx_rsp_valid), .rsp_data(cx_rsp_data)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_CTRL:  reg_rdata[CTRL_W-1:0]   = ctrl_q;
      SEL_AUD:   reg_rdata[SAMPLE_W-1:0] = ch_head[0];
      SEL_TEL:   reg_rdata[SAMPLE_W-1:0] = ch_head[1];
      SEL_CODEC: reg_rdata[CMD_W-1:0]    = cx_reply;
      SEL_STAT:  reg_rdata[STAT_W-1:0]   = stat;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = (|(svc_vec & ctrl_q[MASK_LO +: 2*NUM_CH])) ||
               (ctrl_q[ERR_B] && (|err_vec));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q[MASK_LO +: 2*NUM_CH] == '0) && !ctrl_q[ERR_B]) |-> !irq);

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

  // R11
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $past(!enable)) |-> (!aud_tx_valid && !tel_tx_valid && stat[ERR_LO] == 1'b0));

endmodule

// File: tb/test_codec_port_hub.sv
module test_codec_port_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cfg_enable, cfg_ext_clk;
  logic [3:0]  cfg_aud_rate, cfg_tel_rate;
  logic        aud_tx_valid, aud_tx_ready = 1'b0, aud_rx_valid = 1'b0, aud_rx_ready;
  logic [15:0] aud_tx_data, aud_rx_data = '0;
  logic        tel_tx_valid, tel_tx_ready = 1'b0, tel_rx_valid = 1'b0, tel_rx_ready;
  logic [15:0] tel_tx_data, tel_rx_data = '0;
  logic        cx_req_valid, cx_req_ready = 1'b0, cx_rsp_valid = 1'b0;
  logic [20:0] cx_req_data, cx_rsp_data = '0;
  logic        aud_codec_on = 1'b0, tel_codec_on = 1'b0, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  localparam logic [31:0] CTRL_BASE = 32'h257; // enable, ext clk, rates 5 and 9

  always #10 clk = ~clk;

  codec_port_hub i_codec_port_hub (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic stat_bit(input int b, input logic exp, input string tag);
    logic [31:0] s;
    rd(3'd4, s);
    chk(s[b] == exp, tag, s[b], exp);
  endtask

  task automatic aud_pull(output logic v, output logic [15:0] d);
    @(negedge clk); aud_tx_ready = 1'b1;
    #1 v = aud_tx_valid; d = aud_tx_data;
    @(negedge clk); aud_tx_ready = 1'b0;
  endtask

  task automatic tel_pull(output logic v, output logic [15:0] d);
    @(negedge clk); tel_tx_ready = 1'b1;
    #1 v = tel_tx_valid; d = tel_tx_data;
    @(negedge clk); tel_tx_ready = 1'b0;
  endtask

  task automatic aud_push(input logic [15:0] d, output logic rdy);
    @(negedge clk); aud_rx_valid = 1'b1; aud_rx_data = d;
    #1 rdy = aud_rx_ready;
    @(negedge clk); aud_rx_valid = 1'b0;
  endtask

  task automatic tel_push(input logic [15:0] d);
    @(negedge clk); tel_rx_valid = 1'b1; tel_rx_data = d;
    @(negedge clk); tel_rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk(d == 0, "R1 ctrl after reset", d, 0);
    rd(3'd4, d); chk(d == 32'h0505, "R1 status after reset", d, 32'h0505);
    chk(!irq && !aud_tx_valid && !aud_rx_ready && !tel_rx_ready, "R1 outputs idle",
        {irq, aud_tx_valid, aud_rx_ready, tel_rx_ready}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(3'd0, CTRL_BASE);
    rd(3'd0, d); chk(d == CTRL_BASE, "R2 ctrl readback", d, CTRL_BASE);
    chk({cfg_enable, cfg_ext_clk, cfg_aud_rate, cfg_tel_rate} == {2'b11, 4'd5, 4'd9},
        "R2 cfg pins", {cfg_enable, cfg_ext_clk, cfg_aud_rate, cfg_tel_rate}, {2'b11, 4'd5, 4'd9});
  endtask

  task automatic t_audio_order();
    logic v, r; logic [15:0] x; logic [31:0] d;
    wr(3'd1, 32'hFFFF_1111); wr(3'd1, 32'h2222); wr(3'd1, 32'h3333);
    for (int i = 0; i < 3; i++) begin
      aud_pull(v, x);
      chk(v && x == 16'h1111 * (i + 1), "R3 audio tx order", {v, x}, {1'b1, 16'h1111 * (i + 1)});
    end
    aud_push(16'h00A1, r); aud_push(16'h00A2, r);
    rd(3'd1, d); chk(d == 32'hA1, "R3 audio rx first", d, 32'hA1);
    rd(3'd1, d); chk(d == 32'hA2, "R3 audio rx second", d, 32'hA2);
    rd(3'd1, d); chk(d == 0, "R3 audio rx empty read", d, 0);
  endtask

  task automatic t_tel_indep();
    logic v; logic [15:0] x; logic [31:0] d;
    wr(3'd2, 32'h7E7E);
    #1 chk(!aud_tx_valid && tel_tx_valid && tel_tx_data == 16'h7E7E, "R4 telecom tx separate",
           {aud_tx_valid, tel_tx_valid, tel_tx_data}, {2'b01, 16'h7E7E});
    tel_pull(v, x);
    tel_push(16'hBEEF);
    rd(3'd4, d); chk(d[11] && !d[9], "R9 tel rx not-empty only", d[11:8], 4'b1000 | {2'b0, d[9], 1'b0});
    rd(3'd2, d); chk(d == 32'hBEEF, "R4 telecom rx read", d, 32'hBEEF);
  endtask

  task automatic t_tx_fill();
    logic v; logic [15:0] x;
    for (int i = 1; i <= 4; i++) wr(3'd1, 32'h100 + i);
    stat_bit(0, 1'b1, "R7 audio tx svc at 4");
    wr(3'd1, 32'h105);
    stat_bit(0, 1'b0, "R7 audio tx svc at 5");
    for (int i = 6; i <= 8; i++) wr(3'd1, 32'h100 + i);
    stat_bit(8, 1'b0, "R9 audio tx full");
    wr(3'd1, 32'hDEAD);
    for (int i = 1; i <= 8; i++) begin
      aud_pull(v, x);
      chk(v && x == 16'h100 + i, "R5 audio tx full drop", {v, x}, {1'b1, 16'h100 + i});
    end
    aud_pull(v, x);
    chk(!v, "R5 audio tx empty after 8", v, 0);
    stat_bit(4, 1'b1, "R6 audio underrun set");
    stat_bit(5, 1'b0, "R6 audio overrun clear");
  endtask

  task automatic t_irq();
    logic [31:0] d;
    #1 chk(!irq, "R10 irq masked", irq, 0);
    wr(3'd0, CTRL_BASE | (32'h1 << 14));
    #1 chk(irq, "R10 irq on error", irq, 1);
    wr(3'd4, 32'h10);
    rd(3'd4, d); chk(!d[4] && !irq, "R6 w1c underrun", {d[4], irq}, 0);
    wr(3'd0, CTRL_BASE | (32'h1 << 10));
    #1 chk(irq, "R10 irq on tx svc", irq, 1);
    wr(3'd0, CTRL_BASE);
    #1 chk(!irq, "R10 irq unmasked off", irq, 0);
  endtask

  task automatic t_rx_fill();
    logic r; logic [31:0] d;
    for (int i = 1; i <= 3; i++) aud_push(16'h200 + i, r);
    stat_bit(1, 1'b0, "R7 audio rx svc at 3");
    aud_push(16'h204, r);
    stat_bit(1, 1'b1, "R7 audio rx svc at 4");
    for (int i = 5; i <= 8; i++) aud_push(16'h200 + i, r);
    aud_push(16'h0BAD, r);
    chk(!r, "R5 audio rx full ready", r, 0);
    stat_bit(5, 1'b1, "R5 audio overrun set");
    for (int i = 1; i <= 8; i++) begin
      rd(3'd1, d);
      chk(d == 32'h200 + i, "R5 audio rx content", d, 32'h200 + i);
    end
    wr(3'd4, 32'h20);
    stat_bit(5, 1'b0, "R6 w1c overrun");
  endtask

  task automatic t_codec();
    logic [31:0] d;
    wr(3'd3, 32'hFFFF_FFFF & 32'h1ABCDE);
    #1 chk(cx_req_valid && cx_req_data == 21'h1ABCDE, "R8 request out",
           {cx_req_valid, cx_req_data}, {1'b1, 21'h1ABCDE});
    stat_bit(12, 1'b0, "R8 done clear after write");
    #1 chk(cx_req_valid, "R8 request held", cx_req_valid, 1);
    @(negedge clk); cx_req_ready = 1'b1;
    @(negedge clk); cx_req_ready = 1'b0;
    chk(!cx_req_valid, "R8 request taken", cx_req_valid, 0);
    @(negedge clk); cx_rsp_valid = 1'b1; cx_rsp_data = 21'h054321;
    @(negedge clk); cx_rsp_valid = 1'b0;
    stat_bit(12, 1'b1, "R8 done after reply");
    rd(3'd3, d); chk(d == 32'h054321, "R8 reply read", d, 32'h054321);
    wr(3'd3, 32'h777);
    stat_bit(12, 1'b0, "R8 done cleared by write");
  endtask

  task automatic t_codec_on();
    logic [31:0] d;
    @(negedge clk); aud_codec_on = 1'b1;
    rd(3'd4, d);
    chk(d[13] && !d[14] && !irq, "R9 codec on bits no irq", {d[14:13], irq}, 3'b010);
  endtask

  task automatic t_disable();
    logic v; logic [15:0] x; logic [31:0] d;
    aud_pull(v, x);
    wr(3'd2, 32'h4444);
    stat_bit(4, 1'b1, "R6 underrun before disable");
    wr(3'd0, CTRL_BASE & ~32'h1);
    rd(3'd4, d);
    chk(!d[4] && !tel_tx_valid && !aud_rx_ready, "R11 disabled clears",
        {d[4], tel_tx_valid, aud_rx_ready}, 0);
    aud_pull(v, x);
    stat_bit(4, 1'b0, "R11 no underrun while off");
    wr(3'd0, CTRL_BASE);
    #1 chk(!tel_tx_valid, "R11 telecom tx flushed", tel_tx_valid, 0);
    stat_bit(10, 1'b1, "R11 telecom tx not full after flush");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_audio_order();
    t_tel_indep();
    t_tx_fill();
    t_irq();
    t_rx_fill();
    t_codec();
    t_codec_on();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule